// File: doc/BRIEF.md
# XOR-Keyed Mode and Status Register Pair

This block holds two configuration registers on a small register bus. One is a writable mode register. The other is a read-only status register that mirrors the mode bits now in effect. Writes to the mode register are keyed. The value that gets stored is the bus data XORed with the present contents of both registers, not the bus data itself.

To load a desired value, software reads both registers, XORs the two results together, XORs that with the desired value, and writes the result to the mode register. The keying then cancels and the register ends up holding exactly the desired value.

Two bits of the stored mode drive the rest of the chip:
- a double-data-rate output enable;
- a clock-generator range select, slow or fast.

The block also takes a sample-rate code in MSPS. It raises a range-fault flag whenever that rate lies outside the operating window of the selected range.

Top module: `cfgpair_top`

## Requirements
- R1: After reset the mode register reads 0x00, the status register reads 0x00, `ddr_en` is 0 and `dll_slow` is 0 (fast range).
- R2: A write (`wr_en`=1) to address 0x74 stores `wdata ^ mode ^ status` at the clock edge, where mode and status are the values before that edge.
- R3: A read of address 0x74 returns the stored mode. A read of 0x75 returns the status value: bit 6 equals the range select, bit 4 equals the DDR enable, and all other bits are 0. Both reads are combinational.
- R4: The sequence "read 0x74, read 0x75, write their XOR combined with D to 0x74" leaves D in the mode register for any 8-bit D.
- R5: A write to address 0x75 changes neither register.
- R6: Writes to any address other than 0x74 and 0x75 change nothing, and reads of those addresses return 0x00.
- R7: `dll_slow` equals bit 6 of the stored mode (1 = slow range, 0 = fast range). `ddr_en` equals bit 4.
- R8: With the slow range selected, `range_fault` is 1 exactly when `rate_msps` < 80 or `rate_msps` > 200.
- R9: With the fast range selected, `range_fault` is 1 exactly when `rate_msps` < 160 or `rate_msps` > 500.
- R10: While `wr_en` is 0 the mode register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Register address for both reads and writes |
| wdata | input | 8 | Write data (XOR key input) |
| rdata | output | 8 | Combinational read data for `addr` |
| rate_msps | input | 10 | Sample-rate code in MSPS |
| ddr_en | output | 1 | Effective DDR output enable |
| dll_slow | output | 1 | Effective clock-generator range (1 = slow) |
| range_fault | output | 1 | Rate outside the selected range's window |

## Verification
The assertions treat `addr`, `wdata`, `wr_en` and `rate_msps` as settled at every rising edge, and they allow any value on those inputs. The rate code is assumed to be a plain unsigned MSPS count that may lie outside both windows.

The stimulus changes inputs only on falling edges. Random addresses are drawn mostly from the two mapped locations, with a share of unmapped ones. Random rates span 0 to 600, so both windows and their edges are covered. Directed steps place the rate exactly on each window bound and one MSPS past it, in both ranges.

// File: rtl/cfgpair_pkg.sv
package cfgpair_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int RATE_W = 10;

  typedef logic [DATA_W-1:0] cfg_byte_t;

  // Keyed write: new value is data folded with both current register values.
  function automatic cfg_byte_t keyed_update(cfg_byte_t wd, cfg_byte_t cur, cfg_byte_t stat);
    return wd ^ cur ^ stat;
  endfunction

  // Inclusive window test.
  function automatic logic rate_in_window(logic [RATE_W-1:0] r, int lo, int hi);
    return (int'(r) >= lo) && (int'(r) <= hi);
  endfunction
endpackage

// File: rtl/cfgpair_regfile.sv
module cfgpair_regfile
  import cfgpair_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h74,
  parameter int DLL_BIT = 6,
  parameter int DDR_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  cfg_byte_t         wdata,
  output cfg_byte_t         mode_q,
  output cfg_byte_t         status
);
  localparam cfg_byte_t STAT_MASK = cfg_byte_t'((1 << DLL_BIT) | (1 << DDR_BIT));

  logic mode_wr;
  assign mode_wr = wr_en && (addr == MODE_ADDR);
  assign status  = mode_q & STAT_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= keyed_update(wdata, mode_q, status);
  end

  // R2: keyed store
  a_r2_keyed_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MODE_ADDR) |=> (mode_q == $past(wdata ^ mode_q ^ status)));
  // R5 and R6: writes elsewhere leave the mode untouched
  a_r5_other_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != MODE_ADDR) |=> $stable(mode_q));
  // R10: idle hold
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
  // R3: status carries only the two mode bits
  a_r3_status_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~STAT_MASK) == '0);
endmodule

// File: rtl/cfgpair_readmux.sv
module cfgpair_readmux
  import cfgpair_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h74,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  cfg_byte_t         mode_q,
  input  cfg_byte_t         status,
  output cfg_byte_t         rdata
);
  logic hit_mode, hit_stat;
  assign hit_mode = (addr == MODE_ADDR);
  assign hit_stat = (addr == STAT_ADDR);

  always_comb begin
    rdata = '0;
    if (hit_mode)      rdata = mode_q;
    else if (hit_stat) rdata = status;
  end

  // R6: unmapped reads are zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_mode && !hit_stat) |-> (rdata == '0));
  // R3: single select
  a_r3_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_mode, hit_stat}));
endmodule

// File: rtl/cfgpair_rangechk.sv
module cfgpair_rangechk
  import cfgpair_pkg::*;
#(
  parameter int SLOW_MIN = 80,
  parameter int SLOW_MAX = 200,
  parameter int FAST_MIN = 160,
  parameter int FAST_MAX = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_slow,
  input  logic [RATE_W-1:0] rate_msps,
  output logic              range_fault
);
  logic slow_ok, fast_ok;
  assign slow_ok     = rate_in_window(rate_msps, SLOW_MIN, SLOW_MAX);
  assign fast_ok     = rate_in_window(rate_msps, FAST_MIN, FAST_MAX);
  assign range_fault = dll_slow ? !slow_ok : !fast_ok;

  // R8: slow range bounds
  a_r8_slow_out: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_slow && (int'(rate_msps) < SLOW_MIN || int'(rate_msps) > SLOW_MAX)) |-> range_fault);
  // R9: fast range bounds
  a_r9_fast_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!dll_slow && (int'(rate_msps) < FAST_MIN || int'(rate_msps) > FAST_MAX)) |-> range_fault);
  // R8/R9: overlap region is claimed by both ranges
  a_r9_overlap_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rate_msps) >= FAST_MIN && int'(rate_msps) <= SLOW_MAX) |-> !range_fault);
endmodule

// File: rtl/cfgpair_top.sv
module cfgpair_top
  import cfgpair_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h74,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h75,
  parameter int DLL_BIT  = 6,
  parameter int DDR_BIT  = 4,
  parameter int SLOW_MIN = 80,
  parameter int SLOW_MAX = 200,
  parameter int FAST_MIN = 160,
  parameter int FAST_MAX = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [RATE_W-1:0] rate_msps,
  output logic              ddr_en,
  output logic              dll_slow,
  output logic              range_fault
);
  cfg_byte_t mode_q, status;

  cfgpair_regfile #(.MODE_ADDR(MODE_ADDR), .DLL_BIT(DLL_BIT), .DDR_BIT(DDR_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .status(status));

  cfgpair_readmux #(.MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)) u_rd (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mode_q(mode_q), .status(status), .rdata(rdata));

  assign dll_slow = mode_q[DLL_BIT];
  assign ddr_en   = mode_q[DDR_BIT];

  cfgpair_rangechk #(.SLOW_MIN(SLOW_MIN), .SLOW_MAX(SLOW_MAX),
                     .FAST_MIN(FAST_MIN), .FAST_MAX(FAST_MAX)) u_rng (
    .clk(clk), .rst_n(rst_n), .dll_slow(dll_slow), .rate_msps(rate_msps),
    .range_fault(range_fault));

  // R7: effective bits follow the status register
  a_r7_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (status[DLL_BIT] == dll_slow) && (status[DDR_BIT] == ddr_en));
endmodule

// File: tb/cfgpair_tb.sv
`timescale 1ns/100ps
module cfgpair_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [9:0] rate_msps = 10'd300;
  logic       ddr_en, dll_slow, range_fault;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_mode = 8'h00;
  bit finished = 0;

  always #2 clk = ~clk;

  cfgpair_top dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rate_msps(rate_msps), .ddr_en(ddr_en), .dll_slow(dll_slow),
    .range_fault(range_fault));

  function automatic logic [7:0] m_stat(logic [7:0] m);
    return {1'b0, m[6], 1'b0, m[4], 4'b0000};
  endfunction

  function automatic logic m_fault(logic slow, int r);
    if (slow) return (r < 80) || (r > 200);
    return (r < 160) || (r > 500);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called shortly after a falling edge, with wr_en low.
  task automatic check_state(string req);
    addr = 8'h74; #0.4; chk({req, " R3 mode read"}, rdata, m_mode);
    addr = 8'h75; #0.4; chk({req, " R3 status read"}, rdata, m_stat(m_mode));
    addr = 8'h20; #0.4; chk({req, " R6 unmapped read"}, rdata, 0);
    chk({req, " R7 dll_slow"}, dll_slow, m_mode[6]);
    chk({req, " R7 ddr_en"}, ddr_en, m_mode[4]);
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == 8'h74) m_mode = m_mode ^ d ^ m_stat(m_mode);
    @(negedge clk);
    wr_en = 1'b0;
    #0.2;
  endtask

  task automatic sw_set(logic [7:0] want);
    logic [7:0] r74, r75;
    @(negedge clk); wr_en = 1'b0;
    addr = 8'h74; #0.4; r74 = rdata;
    addr = 8'h75; #0.4; r75 = rdata;
    bus_write(8'h74, r74 ^ r75 ^ want);
    chk("R4 procedure result", m_mode, want);
    addr = 8'h74; #0.4; chk("R4 readback", rdata, want);
  endtask

  task automatic rate_probe(int r, string req);
    rate_msps = 10'(r); #0.4;
    chk(req, range_fault, m_fault(dll_slow, r));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    #0.2;
    check_state("R1 reset");
    chk("R1 dll fast", dll_slow, 0);
    rst_n = 1'b1;
    @(negedge clk); #0.2;

    // R2: raw keyed write
    bus_write(8'h74, 8'h5A);
    check_state("R2 keyed write");
    bus_write(8'h74, 8'hFF);
    check_state("R2 keyed write twice");

    // R4: procedure from various states
    sw_set(8'h50);
    check_state("R4 both on");
    sw_set(8'h00);
    sw_set(8'hC3);
    sw_set(8'h10);

    // R5: status write ignored
    sw_set(8'h40);
    bus_write(8'h75, 8'hFF);
    check_state("R5 status write");
    // R6: unmapped write ignored
    bus_write(8'h33, 8'hAA);
    check_state("R6 unmapped write");

    // R10: idle cycles with data changing
    @(negedge clk); wdata = 8'hEE; addr = 8'h74;
    repeat (3) @(negedge clk);
    #0.2; check_state("R10 idle hold");

    // R8: slow range bounds (mode 0x40 = slow)
    rate_probe(79, "R8 below slow");
    rate_probe(80, "R8 slow min");
    rate_probe(200, "R8 slow max");
    rate_probe(201, "R8 above slow");
    rate_probe(180, "R8 overlap");
    // R9: fast range bounds
    sw_set(8'h00);
    rate_probe(159, "R9 below fast");
    rate_probe(160, "R9 fast min");
    rate_probe(500, "R9 fast max");
    rate_probe(501, "R9 above fast");
    rate_probe(180, "R9 overlap");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      logic       w;
      int         sel, r;
      sel = $urandom_range(0, 9);
      a = (sel < 5) ? 8'h74 : (sel < 8) ? 8'h75 : 8'($urandom_range(0, 255));
      d = 8'($urandom_range(0, 255));
      w = 1'($urandom_range(0, 1));
      r = $urandom_range(0, 600);
      @(negedge clk);
      wr_en = 1'b0; rate_msps = 10'(r);
      #0.2;
      check_state("R2 random");
      chk("R8 R9 random fault", range_fault, m_fault(m_mode[6], r));
      wr_en = w; addr = a; wdata = d;
      @(posedge clk);
      if (w && a == 8'h74) m_mode = m_mode ^ d ^ m_stat(m_mode);
    end
    @(negedge clk); wr_en = 1'b0; #0.2;
    check_state("R2 final");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule